// File: doc/BRIEF.md
# Stereo Serial Audio Receiver

This block turns a two-channel serial audio stream into parallel sample words. It watches a bit clock, a word clock, a left/right clock and a serial data line. All four are brought into one fast system clock domain through two-flop synchronizers, and their edges are found there. The system clock has to run at four times the bit-clock rate or faster. Static configuration pins set the format: which bit-clock edge samples data, which signal marks the start of a word, whether the first data bit lags the framing event by one bit period, and how many bits a word holds.

A channel word arrives most significant bit first. The block captures the configured number of bits and discards whatever else fills the slot. It then presents the word sign-extended to 24 bits, together with a one-cycle valid pulse and a tag that names the channel. A framing event that arrives before the current word is complete throws the partial word away and starts capture again.

Top module: `stereo_serial_rx`

## Requirements
- R1: Data bits are shifted in most significant bit first. The delivered word is made of the first N bits captured after the start of the word, where N is the effective word length.
- R2: With `cfg_fall_edge` low, bits are taken on rising edges of `sclk_in`. With it high, bits are taken on falling edges.
- R3: With `cfg_lr_frame` high, every transition of `lrclk_in`, rising or falling, starts a new word. The channel tag is the `lrclk_in` level just after the event: 0 means left and 1 means right.
- R4: With `cfg_lr_frame` low, a rising edge of `wclk_in` starts a new word, and the `lrclk_in` level at that moment gives the tag. With `cfg_lr_frame` high, `wclk_in` has no effect on the output.
- R5: With `cfg_msb_late` low, the first data bit is the one taken on the first sampling edge after the framing event. With it high, that first sampling edge is skipped and the second one supplies the first bit. A sampling edge that falls in the same system cycle as the framing event does not count.
- R6: `smp_valid` is high for exactly one system cycle per finished word. `smp_data` and `smp_right` hold the word and its tag in that cycle, and they keep those values until the next word is delivered.
- R7: `smp_data` is the received word in two's complement, sign-extended to 24 bits. Every bit above position N-1 equals bit N-1.
- R8: The effective length N is `cfg_word_len` limited to the range 4 to 20. Values below 4 act as 4 and values above 20 act as 20. Bits after the Nth bit of a slot are discarded.
- R9: A framing event that arrives while a word is still being captured drops that partial word. No valid pulse is raised for it, and capture starts again from the new event.
- R10: While reset is applied and after it is released, `smp_valid`, `smp_data` and `smp_right` are 0 until the first word is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the bit-clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_in | input | 1 | Serial bit clock |
| wclk_in | input | 1 | Word clock; its rising edge starts a word in word-clock mode |
| lrclk_in | input | 1 | Left/right clock; its level selects the channel |
| sdata_in | input | 1 | Serial data, most significant bit first |
| cfg_fall_edge | input | 1 | 0: sample on rising bit-clock edges; 1: sample on falling edges |
| cfg_lr_frame | input | 1 | 1: left/right transitions start words; 0: word-clock rising edges start words |
| cfg_msb_late | input | 1 | 1: first data bit arrives one bit period after the framing event |
| cfg_word_len | input | 5 | Requested word length in bits, limited to 4..20 |
| smp_data | output | 24 | Sign-extended received word |
| smp_valid | output | 1 | One-cycle pulse when a word is complete |
| smp_right | output | 1 | Channel tag of the delivered word: 0 left, 1 right |

## Verification
The hardest case to reach from the ports is a framing event that cuts into a word already partly captured. In normal framing, every slot is long enough to finish its word before the next event. The bench therefore includes directed frames that send only a few bits of a slot and then start another word. In left/right mode the new word starts on an early left/right transition. In word-clock mode it starts on a second word-clock pulse while the left/right level stays the same. The random frames keep `wclk_in` toggling in left/right mode, so any reaction to the word clock would corrupt words. They also mix in word lengths outside 4..20, so the length limits are exercised.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int SRX_OUT_W    = 24;
  localparam int SRX_MAX_BITS = 20;
  localparam int SRX_MIN_BITS = 4;
  localparam int SRX_LEN_W    = 5;
  localparam int SRX_SYNC     = 2;
  localparam int SRX_NSIG     = 4;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  localparam int CW = W * STAGES;

  logic [CW-1:0] chain_q;
  logic [CW-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[CW-W-1:0], d_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign d_out = chain_q[CW-1 -: W];
endmodule

// File: rtl/srx_frame.sv
module srx_frame (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_s,
  input  logic wclk_s,
  input  logic lr_s,
  input  logic cfg_fall_edge,
  input  logic cfg_lr_frame,
  output logic frame_evt,
  output logic samp_evt,
  output logic chan
);
  logic sclk_q, wclk_q, lr_q;
  logic sclk_rise, sclk_fall, wclk_rise, lr_flip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      wclk_q <= 1'b0;
      lr_q   <= 1'b0;
    end else begin
      sclk_q <= sclk_s;
      wclk_q <= wclk_s;
      lr_q   <= lr_s;
    end
  end

  always_comb begin
    sclk_rise = sclk_s & ~sclk_q;
    sclk_fall = ~sclk_s & sclk_q;
    wclk_rise = wclk_s & ~wclk_q;
    lr_flip   = lr_s ^ lr_q;
    samp_evt  = cfg_fall_edge ? sclk_fall : sclk_rise;
    frame_evt = cfg_lr_frame ? lr_flip : wclk_rise;
    chan      = lr_s;
  end

  // R3: in left/right mode a framing event always coincides with a channel change
  a_r3_lr_event_flips: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_lr_frame && frame_evt) |-> (chan != $past(chan)));

  // R2: a sampling event follows a bit-clock level change
  a_r2_samp_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    samp_evt |-> (sclk_s != $past(sclk_s)));
endmodule

// File: rtl/srx_capture.sv
module srx_capture #(
  parameter int MAX_BITS = 20,
  parameter int MIN_BITS = 4,
  parameter int OUT_W    = 24,
  parameter int LEN_W    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_evt,
  input  logic             samp_evt,
  input  logic             chan,
  input  logic             sdata_s,
  input  logic             cfg_msb_late,
  input  logic [LEN_W-1:0] cfg_word_len,
  output logic [OUT_W-1:0] smp_data,
  output logic             smp_valid,
  output logic             smp_right
);
  localparam int CNT_W = $clog2(MAX_BITS + 1);

  logic                busy_q, busy_d;
  logic                skip_q, skip_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d, cnt_inc;
  logic [MAX_BITS-1:0] sh_q, sh_d;
  logic                chan_q, chan_d;
  logic [OUT_W-1:0]    data_q, data_d;
  logic                valid_q, valid_d;
  logic                right_q, right_d;
  logic [CNT_W-1:0]    len_eff;

  function automatic logic [OUT_W-1:0] sext(input logic [MAX_BITS-1:0] w,
                                            input logic [CNT_W-1:0] n);
    logic [OUT_W-1:0] r;
    for (int i = 0; i < OUT_W; i++) begin
      if (i < int'(n)) r[i] = (i < MAX_BITS) ? w[i] : 1'b0;
      else             r[i] = w[int'(n) - 1];
    end
    return r;
  endfunction

  always_comb begin
    if (int'(cfg_word_len) < MIN_BITS)      len_eff = CNT_W'(MIN_BITS);
    else if (int'(cfg_word_len) > MAX_BITS) len_eff = CNT_W'(MAX_BITS);
    else                                    len_eff = CNT_W'(cfg_word_len);
  end

  always_comb begin
    busy_d  = busy_q;
    skip_d  = skip_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    chan_d  = chan_q;
    data_d  = data_q;
    right_d = right_q;
    valid_d = 1'b0;
    cnt_inc = cnt_q + CNT_W'(1);
    if (frame_evt) begin
      busy_d = 1'b1;
      skip_d = cfg_msb_late;
      cnt_d  = '0;
      sh_d   = '0;
      chan_d = chan;
    end else if (busy_q && samp_evt) begin
      if (skip_q) begin
        skip_d = 1'b0;
      end else begin
        sh_d  = {sh_q[MAX_BITS-2:0], sdata_s};
        cnt_d = cnt_inc;
        if (cnt_inc == len_eff) begin
          busy_d  = 1'b0;
          valid_d = 1'b1;
          right_d = chan_q;
          data_d  = sext(sh_d, len_eff);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      skip_q  <= 1'b0;
      cnt_q   <= '0;
      sh_q    <= '0;
      chan_q  <= 1'b0;
      data_q  <= '0;
      valid_q <= 1'b0;
      right_q <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      skip_q  <= skip_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      chan_q  <= chan_d;
      data_q  <= data_d;
      valid_q <= valid_d;
      right_q <= right_d;
    end
  end

  assign smp_data  = data_q;
  assign smp_valid = valid_q;
  assign smp_right = right_q;

  // R6: valid never lasts more than one cycle
  a_r6_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> !smp_valid);

  // R7: bits at and above the widest word position agree on delivery
  a_r7_sign_ext: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> ((&smp_data[OUT_W-1:MAX_BITS-1]) || !(|smp_data[OUT_W-1:MAX_BITS-1])));

  // R9: a framing event restarts capture from zero bits
  a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
    frame_evt |=> (busy_q && cnt_q == '0));

  // R8: the bit count stays below the effective length while capturing
  a_r8_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q < len_eff));

  // R1: each non-skipped sampling edge adds one bit or finishes the word
  a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && samp_evt && !frame_evt && !skip_q) |=>
      (!busy_q || cnt_q == $past(cnt_q) + CNT_W'(1)));

  // R5: a delayed-MSB event skips the first sampling edge
  a_r5_late_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_evt && cfg_msb_late) |=> skip_q);
endmodule

// File: rtl/stereo_serial_rx.sv
module stereo_serial_rx
  import srx_pkg::*;
#(
  parameter int OUT_W    = SRX_OUT_W,
  parameter int MAX_BITS = SRX_MAX_BITS,
  parameter int MIN_BITS = SRX_MIN_BITS,
  parameter int LEN_W    = SRX_LEN_W,
  parameter int STAGES   = SRX_SYNC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk_in,
  input  logic             wclk_in,
  input  logic             lrclk_in,
  input  logic             sdata_in,
  input  logic             cfg_fall_edge,
  input  logic             cfg_lr_frame,
  input  logic             cfg_msb_late,
  input  logic [LEN_W-1:0] cfg_word_len,
  output logic [OUT_W-1:0] smp_data,
  output logic             smp_valid,
  output logic             smp_right
);
  logic [1:0]          rst_q;
  logic                rst_int_n;
  logic [SRX_NSIG-1:0] raw_sig, sync_sig;
  logic                frame_evt, samp_evt, chan;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_int_n = rst_q[1];

  assign raw_sig = {sdata_in, lrclk_in, wclk_in, sclk_in};

  srx_sync #(.W(SRX_NSIG), .STAGES(STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_in  (raw_sig),
    .d_out (sync_sig)
  );

  srx_frame u_frame (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .sclk_s        (sync_sig[0]),
    .wclk_s        (sync_sig[1]),
    .lr_s          (sync_sig[2]),
    .cfg_fall_edge (cfg_fall_edge),
    .cfg_lr_frame  (cfg_lr_frame),
    .frame_evt     (frame_evt),
    .samp_evt      (samp_evt),
    .chan          (chan)
  );

  srx_capture #(
    .MAX_BITS (MAX_BITS),
    .MIN_BITS (MIN_BITS),
    .OUT_W    (OUT_W),
    .LEN_W    (LEN_W)
  ) u_capture (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .frame_evt    (frame_evt),
    .samp_evt     (samp_evt),
    .chan         (chan),
    .sdata_s      (sync_sig[3]),
    .cfg_msb_late (cfg_msb_late),
    .cfg_word_len (cfg_word_len),
    .smp_data     (smp_data),
    .smp_valid    (smp_valid),
    .smp_right    (smp_right)
  );

  // R10: nothing is delivered while the internal reset is held
  a_r10_quiet_in_reset: assert property (@(posedge clk)
    !rst_int_n |=> (!smp_valid && smp_data == '0));
endmodule

// File: tb/test_stereo_serial_rx.sv
`timescale 1ns/1ps
module test_stereo_serial_rx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk_in = 1'b0, wclk_in = 1'b0, lrclk_in = 1'b1, sdata_in = 1'b0;
  logic        cfg_fall_edge = 1'b0, cfg_lr_frame = 1'b1, cfg_msb_late = 1'b0;
  logic [4:0]  cfg_word_len = 5'd16;
  logic [23:0] smp_data;
  logic        smp_valid, smp_right;

  int nvec = 0, nfail = 0, got_n = 0;
  bit done = 1'b0;
  logic [23:0] log_d [1024];
  logic        log_r [1024];

  always #2.5 clk = ~clk;

  stereo_serial_rx i_stereo_serial_rx (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .wclk_in(wclk_in),
    .lrclk_in(lrclk_in), .sdata_in(sdata_in), .cfg_fall_edge(cfg_fall_edge),
    .cfg_lr_frame(cfg_lr_frame), .cfg_msb_late(cfg_msb_late),
    .cfg_word_len(cfg_word_len), .smp_data(smp_data), .smp_valid(smp_valid),
    .smp_right(smp_right)
  );

  always @(negedge clk) begin
    if (smp_valid) begin
      if (got_n < 1024) begin
        log_d[got_n] = smp_data;
        log_r[got_n] = smp_right;
      end
      got_n = got_n + 1;
    end
  end

  function automatic int clamp_ref(input int l);
    if (l < 4) return 4;
    if (l > 20) return 20;
    return l;
  endfunction

  function automatic logic [23:0] sext_ref(input logic [19:0] v, input int n);
    logic [23:0] r;
    for (int i = 0; i < 24; i++) r[i] = (i < n) ? v[i] : v[n-1];
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one bit period: launch edge with new levels, then the sampling edge
  task automatic bit_slot(input logic d, input logic w, input logic lr);
    @(negedge clk);
    sclk_in  = cfg_fall_edge;
    sdata_in = d;
    wclk_in  = w;
    lrclk_in = lr;
    repeat (3) @(negedge clk);
    sclk_in = ~cfg_fall_edge;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_word(input logic [19:0] val, input logic ch, input int nslots);
    int n = clamp_ref(int'(cfg_word_len));
    for (int k = 0; k < nslots; k++) begin
      int idx = cfg_msb_late ? k - 1 : k;
      logic b = (idx >= 0 && idx < n) ? val[n-1-idx] : logic'($urandom % 2);
      logic w = cfg_lr_frame ? logic'($urandom % 2) : (k == 0);
      bit_slot(b, w, ch);
    end
  endtask

  task automatic idle_slot();
    bit_slot(1'b0, 1'b0, 1'b1);
  endtask

  task automatic send_frame(input string req, input logic [19:0] l, input logic [19:0] r);
    int base;
    int n = clamp_ref(int'(cfg_word_len));
    idle_slot();
    base = got_n;
    send_word(l, 1'b0, 24);
    send_word(r, 1'b1, 24);
    repeat (10) @(negedge clk);
    chk({req, " word count"}, got_n - base, 2);
    chk({req, " left word"}, log_d[base % 1024], sext_ref(l, n));
    chk("R6 left tag", log_r[base % 1024], 1'b0);
    chk({req, " right word"}, log_d[(base + 1) % 1024], sext_ref(r, n));
    chk("R6 right tag", log_r[(base + 1) % 1024], 1'b1);
  endtask

  initial begin
    void'($urandom(32'h5EED_0A17));
    repeat (5) @(negedge clk);
    // R10: reset state
    chk("R10 valid in reset", smp_valid, 0);
    chk("R10 data in reset", smp_data, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R10 valid after reset", smp_valid, 0);
    chk("R10 data after reset", smp_data, 0);
    chk("R10 tag after reset", smp_right, 0);

    // directed corner cases
    cfg_lr_frame = 1'b1; cfg_msb_late = 1'b0; cfg_fall_edge = 1'b0; cfg_word_len = 5'd16;
    send_frame("R1 R3", 20'h0_8001, 20'h0_7FFE);
    cfg_fall_edge = 1'b1;
    send_frame("R2", 20'h0_A5C3, 20'h0_3C5A);
    cfg_msb_late = 1'b1;
    send_frame("R5", 20'h0_C001, 20'h0_4002);
    cfg_lr_frame = 1'b0; cfg_fall_edge = 1'b0; cfg_msb_late = 1'b1;
    send_frame("R4", 20'h0_1234, 20'h0_FEDC);
    cfg_word_len = 5'd4;
    send_frame("R7", 20'h0_0008, 20'h0_0007);
    cfg_word_len = 5'd20;
    send_frame("R7", 20'h8_0000, 20'h7_FFFF);
    cfg_word_len = 5'd2;
    send_frame("R8 low clamp", 20'h0_0009, 20'h0_0006);
    cfg_word_len = 5'd31;
    send_frame("R8 high clamp", 20'hF_0F0F, 20'h1_2345);

    // R9: word-clock restart with the channel level unchanged
    begin
      int base;
      cfg_lr_frame = 1'b0; cfg_msb_late = 1'b0; cfg_word_len = 5'd16;
      idle_slot();
      base = got_n;
      send_word(20'h0_FFFF, 1'b0, 5);
      send_word(20'h0_1357, 1'b0, 24);
      repeat (10) @(negedge clk);
      chk("R9 wclk restart count", got_n - base, 1);
      chk("R9 wclk restart word", log_d[base % 1024], sext_ref(20'h0_1357, 16));
      chk("R9 wclk restart tag", log_r[base % 1024], 1'b0);
    end
    // R9 and R3: early left/right flip drops the left word
    begin
      int base;
      cfg_lr_frame = 1'b1;
      idle_slot();
      base = got_n;
      send_word(20'h0_FFFF, 1'b0, 5);
      send_word(20'h0_9ABC, 1'b1, 24);
      repeat (10) @(negedge clk);
      chk("R9 lr restart count", got_n - base, 1);
      chk("R3 lr restart word", log_d[base % 1024], sext_ref(20'h0_9ABC, 16));
      chk("R3 lr restart tag", log_r[base % 1024], 1'b1);
    end

    // constrained random frames; wclk toggles randomly in lr mode (R4)
    for (int f = 0; f < 120; f++) begin
      cfg_fall_edge = logic'($urandom % 2);
      cfg_lr_frame  = logic'($urandom % 2);
      cfg_msb_late  = logic'($urandom % 2);
      cfg_word_len  = 5'($urandom % 32);
      send_frame(cfg_lr_frame ? "R4 random" : "R1 random",
                 20'($urandom), 20'($urandom));
    end

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nvec++;
      nfail++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule